// File: doc/BRIEF.md
# 3x3 Raster-Scan Image Convolver

The block filters a non-interlaced image stream with a 3x3 coefficient kernel. Pixels arrive one per accepted clock in raster order, left to right and top to bottom. Two on-chip row delays hold the two rows before the current one, so the caller keeps no frame store. Each accepted pixel completes a 3x3 window: the current row and the two rows before it, at the current column and the two columns before it. The nine pixels are multiplied by unsigned 8-bit coefficients and summed into a registered 20-bit result. That width holds the largest possible sum.

A small register port sets up the block before streaming. It has a 3-bit address, a data bus, a chip select and a load strobe. Through it the caller sets the row length, which can be any value up to the row-delay depth. It also loads coefficients into either of two kernel banks and picks the bank in use. A window that would reach past the top or left edge of the image gives no result. The result bus reads as zero while output enable is low.

Top module: `conv3x3_core`

## Requirements
- R1: After reset the valid flag and the result bus are low, both kernel banks hold all-zero coefficients, bank 0 is active, and the row length is 1024.
- R2: A configuration write takes effect only in a cycle where chip select and load strobe are both high. With either one low, the write changes no register.
- R3: Each coefficient is loaded in two writes. Address 2 sets a pointer: data bit 4 is the bank and data bits 3:0 are the tap. Address 3 then stores data bits 7:0 into the tap the pointer names. A pointer with a tap of 9 to 15 makes the value write change nothing.
- R4: Address 2 and address 3 can load coefficients into either bank. Address 1, data bit 0, picks the bank used for filtering.
- R5: Address 0, data bits 9:0, sets the row length minus one, for lengths 1 to 1024. This write also restarts the stream at row 0, column 0.
- R6: A result is the sum of coefficient[3*r+c] times window pixel (r,c). Here r=0 is the oldest of the three rows, c=0 is the leftmost of the three columns, and r=2,c=2 is the pixel just accepted.
- R7: A result is produced, and the valid flag raised for one cycle, only for a pixel at row 2 or later and at column 2 or later of its row. A row shorter than 3 gives no results.
- R8: The valid flag for a pixel rises three clock edges after the edge that accepted the pixel: one edge to form the window and two for the multiply-accumulate path. Gaps in pixel input do not change this delay.
- R9: The result register holds its value between results.
- R10: While output enable is low the result bus reads all zeros. The stored result is still kept.
- R11: With all pixels and all coefficients at 255, the result is 585225 and does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cs_i | input | 1 | Configuration chip select |
| cfg_ld_i | input | 1 | Configuration load strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_data_i | input | 10 | Configuration write data |
| pix_valid_i | input | 1 | Pixel input valid |
| pix_i | input | 8 | Pixel value |
| oe_i | input | 1 | Result bus output enable |
| dout_o | output | 20 | Filtered result |
| dout_valid_o | output | 1 | Result valid, one cycle per result |

## Verification
Some properties are checked on every cycle. Every valid flag must trace back to a pixel accepted exactly three edges earlier at row 2 or later and column 2 or later. The column position must stay within the programmed row length. The row count must saturate at two. The result bus must stay steady between results while it is enabled. The numbers themselves can only be shown by the bench scenarios, which compare each result against a model of the image. These cover the window-to-coefficient mapping, bank selection, ignored or malformed configuration writes, restarts in the middle of a row, short rows and the full-scale sum.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int PIX_W   = 8;
  localparam int COEF_W  = 8;
  localparam int OUT_W   = 20;
  localparam int KDIM    = 3;
  localparam int TAPS    = KDIM * KDIM;
  localparam int NKERN   = 2;
  localparam int TAP_IW  = 4;
  localparam int CFG_AW  = 3;

  typedef enum logic [CFG_AW-1:0] {
    CFG_ROWLEN = 3'd0,
    CFG_KSEL   = 3'd1,
    CFG_CPTR   = 3'd2,
    CFG_CVAL   = 3'd3
  } cfg_addr_e;
endpackage

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs
  import conv_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int DW      = 10,
  parameter int LEN_W   = $clog2(MAX_LEN),
  parameter int KW      = $clog2(NKERN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              ld_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic              len_wr_o,
  output logic [KW-1:0]     ksel_o,
  output logic              coef_we_o,
  output logic [KW-1:0]     coef_kern_o,
  output logic [TAP_IW-1:0] coef_tap_o,
  output logic [COEF_W-1:0] coef_val_o
);
  logic              wr;
  logic [LEN_W-1:0]  len_m1_q;
  logic [KW-1:0]     ksel_q;
  logic [KW-1:0]     ptr_kern_q;
  logic [TAP_IW-1:0] ptr_tap_q;

  assign wr = cs_i & ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_m1_q   <= LEN_W'(MAX_LEN - 1);
      ksel_q     <= '0;
      ptr_kern_q <= '0;
      ptr_tap_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        CFG_ROWLEN: len_m1_q <= data_i[LEN_W-1:0];
        CFG_KSEL:   ksel_q   <= data_i[KW-1:0];
        CFG_CPTR: begin
          ptr_tap_q  <= data_i[TAP_IW-1:0];
          ptr_kern_q <= data_i[TAP_IW +: KW];
        end
        default: ;
      endcase
    end
  end

  assign len_m1_o    = len_m1_q;
  assign len_wr_o    = wr && (addr_i == CFG_ROWLEN);
  assign ksel_o      = ksel_q;
  assign coef_we_o   = wr && (addr_i == CFG_CVAL);
  assign coef_kern_o = ptr_kern_q;
  assign coef_tap_o  = ptr_tap_q;
  assign coef_val_o  = data_i[COEF_W-1:0];
endmodule

// File: rtl/conv_kernel_bank.sv
module conv_kernel_bank
  import conv_pkg::*;
#(
  parameter int KW = $clog2(NKERN)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [KW-1:0]                    kern_i,
  input  logic [TAP_IW-1:0]                tap_i,
  input  logic [COEF_W-1:0]                val_i,
  input  logic [KW-1:0]                    ksel_i,
  output logic [TAPS-1:0][COEF_W-1:0]      coef_o
);
  logic [NKERN-1:0][TAPS-1:0][COEF_W-1:0] bank_q;

  // taps outside 0..TAPS-1 match no slot and are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NKERN; k++) begin
        for (int t = 0; t < TAPS; t++) begin
          if (kern_i == KW'(k) && tap_i == TAP_IW'(t)) bank_q[k][t] <= val_i;
        end
      end
    end
  end

  assign coef_o = bank_q[ksel_i];
endmodule

// File: rtl/conv_linebuf.sv
module conv_linebuf #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int ROWS  = 2
) (
  input  logic                     clk_i,
  input  logic                     en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [W-1:0]             din_i,
  output logic [ROWS-1:0][W-1:0]   tap_o
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] row_in;

    if (g == 0) begin : g_head
      assign row_in = din_i;
    end else begin : g_chain
      assign row_in = tap_o[g-1];
    end

    // read-before-write: same address yields the sample from one row ago
    always_ff @(posedge clk_i) begin
      if (en_i) mem[addr_i] <= row_in;
    end

    assign tap_o[g] = mem[addr_i];
  end
endmodule

// File: rtl/conv_window.sv
module conv_window #(
  parameter int W = 8,
  parameter int K = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic [K-1:0][W-1:0]           col_i,
  output logic [K-1:0][K-1:0][W-1:0]    win_o
);
  // win_q[rows back][columns back]
  logic [K-1:0][K-1:0][W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (shift_i) begin
      for (int r = 0; r < K; r++) begin
        win_q[r][0] <= col_i[r];
        for (int c = 1; c < K; c++) win_q[r][c] <= win_q[r][c-1];
      end
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
  parameter int W     = 8,
  parameter int CW    = 8,
  parameter int OUT_W = 20,
  parameter int K     = 3,
  parameter int TAPS  = K * K
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic [K-1:0][K-1:0][W-1:0]    win_i,
  input  logic [TAPS-1:0][CW-1:0]       coef_i,
  output logic                          vld_o,
  output logic [OUT_W-1:0]              sum_o
);
  localparam int PW = W + CW;

  logic [TAPS-1:0][PW-1:0] prod_q;
  logic                    vld_q;
  logic [OUT_W-1:0]        acc;

  // tap 3*r+c: r=0 oldest row, c=0 leftmost column
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      for (int t = 0; t < TAPS; t++) begin
        prod_q[t] <= PW'(win_i[K-1-t/K][K-1-t%K]) * PW'(coef_i[t]);
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + OUT_W'(prod_q[t]);
  end

  assign vld_o = vld_q;
  assign sum_o = acc;
endmodule

// File: rtl/conv3x3_core.sv
module conv3x3_core
  import conv_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int CFG_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_cs_i,
  input  logic              cfg_ld_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              oe_i,
  output logic [OUT_W-1:0]  dout_o,
  output logic              dout_valid_o
);
  localparam int LEN_W = $clog2(MAX_LEN);
  localparam int KW    = $clog2(NKERN);
  localparam int HIST  = KDIM - 1;

  logic [LEN_W-1:0]  len_m1;
  logic              len_wr;
  logic [KW-1:0]     ksel;
  logic              coef_we;
  logic [KW-1:0]     coef_kern;
  logic [TAP_IW-1:0] coef_tap;
  logic [COEF_W-1:0] coef_val;

  logic [LEN_W-1:0]  col_q;
  logic [1:0]        row_q;
  logic              full_win;
  logic              win_vld_q;

  logic [HIST-1:0][PIX_W-1:0]            lb_tap;
  logic [KDIM-1:0][PIX_W-1:0]            col_vec;
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0]  win;
  logic [TAPS-1:0][COEF_W-1:0]           coef;
  logic                                  mac_vld;
  logic [OUT_W-1:0]                      mac_sum;
  logic [OUT_W-1:0]                      out_q;
  logic                                  out_vld_q;

  conv_cfg_regs #(.MAX_LEN(MAX_LEN), .DW(CFG_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cfg_cs_i),
    .ld_i        (cfg_ld_i),
    .addr_i      (cfg_addr_i),
    .data_i      (cfg_data_i),
    .len_m1_o    (len_m1),
    .len_wr_o    (len_wr),
    .ksel_o      (ksel),
    .coef_we_o   (coef_we),
    .coef_kern_o (coef_kern),
    .coef_tap_o  (coef_tap),
    .coef_val_o  (coef_val)
  );

  conv_kernel_bank u_kbank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we),
    .kern_i (coef_kern),
    .tap_i  (coef_tap),
    .val_i  (coef_val),
    .ksel_i (ksel),
    .coef_o (coef)
  );

  // raster position; row saturates once two history rows exist
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (len_wr) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_valid_i) begin
      if (col_q == len_m1) begin
        col_q <= '0;
        if (row_q != 2'd2) row_q <= row_q + 2'd1;
      end else begin
        col_q <= col_q + LEN_W'(1);
      end
    end
  end

  assign full_win = pix_valid_i && (row_q == 2'd2) && (col_q >= LEN_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_vld_q <= 1'b0;
    else         win_vld_q <= full_win;
  end

  conv_linebuf #(.W(PIX_W), .DEPTH(MAX_LEN), .ROWS(HIST)) u_lbuf (
    .clk_i  (clk_i),
    .en_i   (pix_valid_i),
    .addr_i (col_q),
    .din_i  (pix_i),
    .tap_o  (lb_tap)
  );

  assign col_vec = {lb_tap, pix_i};

  conv_window #(.W(PIX_W), .K(KDIM)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (pix_valid_i),
    .col_i   (col_vec),
    .win_o   (win)
  );

  conv_mac #(.W(PIX_W), .CW(COEF_W), .OUT_W(OUT_W), .K(KDIM)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (win_vld_q),
    .win_i  (win),
    .coef_i (coef),
    .vld_o  (mac_vld),
    .sum_o  (mac_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= mac_vld;
      if (mac_vld) out_q <= mac_sum;
    end
  end

  assign dout_o       = oe_i ? out_q : '0;
  assign dout_valid_o = out_vld_q;
endmodule

// File: rtl/conv3x3_chk.sv
module conv3x3_chk #(
  parameter int LEN_W = 10,
  parameter int OUT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             oe_i,
  input logic [OUT_W-1:0] dout_o,
  input logic             dout_valid_o,
  input logic [1:0]       row_q,
  input logic [LEN_W-1:0] col_q,
  input logic [LEN_W-1:0] len_m1
);
  assert_valid_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> ($past(row_q, 3) == 2'd2 && $past(col_q, 3) >= LEN_W'(2)));

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> $past(pix_valid_i, 3));

  assert_col_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= len_m1);

  assert_row_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= 2'd2);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i) && !dout_valid_o) |-> $stable(dout_o));
endmodule

bind conv3x3_core conv3x3_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_valid_i  (pix_valid_i),
  .oe_i         (oe_i),
  .dout_o       (dout_o),
  .dout_valid_o (dout_valid_o),
  .row_q        (row_q),
  .col_q        (col_q),
  .len_m1       (len_m1)
);

// File: tb/tb_conv3x3_core.sv
`timescale 1ns/1ps
module tb_conv3x3_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_cs = 1'b0, cfg_ld = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [9:0]  cfg_data = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix = '0;
  logic        oe = 1'b1;
  logic [19:0] dout;
  logic        dout_valid;

  int checks = 0, failures = 0;
  int cyc = 0;
  int mk [2][9];
  int bksel = 0, blen = 1024, brow = 0, bcol = 0;
  int hist [3][1024];
  int exp_q[$];
  int cyc_q[$];
  int last_val = 0;
  bit have_last = 0;
  bit mon_on = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv3x3_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_cs_i(cfg_cs), .cfg_ld_i(cfg_ld),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .pix_valid_i(pix_valid),
    .pix_i(pix), .oe_i(oe), .dout_o(dout), .dout_valid_o(dout_valid));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int a, input int d, input bit cs, input bit ld);
    @(negedge clk);
    pix_valid = 0;
    cfg_cs = cs; cfg_ld = ld; cfg_addr = 3'(a); cfg_data = 10'(d);
    @(negedge clk);
    cfg_cs = 0; cfg_ld = 0;
  endtask

  task automatic set_len(input int len);
    cfg_wr(0, len - 1, 1, 1);
    blen = len; brow = 0; bcol = 0;
  endtask

  task automatic set_ksel(input int k);
    cfg_wr(1, k, 1, 1);
    bksel = k;
  endtask

  task automatic load_coef(input int k, input int t, input int v);
    cfg_wr(2, (k << 4) | t, 1, 1);
    cfg_wr(3, v, 1, 1);
    if (t < 9) mk[k][t] = v;
  endtask

  function automatic int model_out(input int r, input int c);
    int s = 0;
    for (int rt = 0; rt < 3; rt++)
      for (int ct = 0; ct < 3; ct++)
        s += mk[bksel][3*rt+ct] * hist[(r-2+rt)%3][c-2+ct];
    return s;
  endfunction

  task automatic push_pix(input int v, input bit vld, input bit rnd_oe);
    @(negedge clk);
    pix_valid = vld; pix = 8'(v);
    oe = rnd_oe ? (($urandom % 4) != 0) : 1'b1;
    if (vld) begin
      hist[brow%3][bcol] = v;
      if (brow >= 2 && bcol >= 2) begin
        exp_q.push_back(model_out(brow, bcol));
        cyc_q.push_back(cyc);
      end
      if (bcol == blen - 1) begin bcol = 0; brow++; end
      else bcol++;
    end
  endtask

  task automatic stream(input int npix, input int fixed, input bit gaps, input bit rnd_oe);
    for (int i = 0; i < npix; i++) begin
      if (gaps) while (($urandom % 10) < 3) push_pix(0, 0, rnd_oe);
      push_pix(fixed >= 0 ? fixed : int'($urandom % 256), 1, rnd_oe);
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 6; i++) push_pix(0, 0, 0);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // output monitor, sampled after the driver settles
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (dout_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected valid", 1, 0);
        end else begin
          int e, c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          chk(cyc == c + 3, "R8 latency", cyc - c, 3);
          if (oe) chk(int'(dout) == e, "R6 result", dout, e);
          else    chk(dout == 0, "R10 disabled bus", dout, 0);
          last_val = e; have_last = 1;
        end
      end else if (!oe) begin
        chk(dout == 0, "R10 disabled bus", dout, 0);
      end else if (have_last) begin
        chk(int'(dout) == last_val, "R9 hold", dout, last_val);
      end
    end
  end

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog R8 actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    foreach (mk[k, t]) mk[k][t] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(dout_valid == 0, "R1 reset valid", dout_valid, 0);
    chk(dout == 0, "R1 reset result", dout, 0);
    mon_on = 1;

    // R11 full scale, with default row length R1
    for (int t = 0; t < 9; t++) load_coef(0, t, 255);
    stream(2 * 1024 + 6, 255, 0, 0);
    chk(exp_q.size() > 0 && exp_q[0] == 585225, "R11 queued full-scale", exp_q.size() > 0 ? exp_q[0] : -1, 585225);
    drain("R1 default length count");
    chk(int'(dout) == 585225, "R11 full-scale", dout, 585225);

    // R1 bank 1 is zero after reset; R4 select
    set_ksel(1);
    set_len(4);
    stream(12, -1, 0, 0);
    drain("R4 bank1 count");
    chk(dout == 0, "R1 zero bank", dout, 0);

    // R6 random kernel, continuous
    for (int t = 0; t < 9; t++) load_coef(0, t, $urandom % 256);
    set_ksel(0);
    set_len(6);
    stream(30, -1, 0, 0);
    drain("R6 count");

    // R3 tap 9..15 ignored, R4 bank 1, gaps and random oe R10
    for (int t = 0; t < 9; t++) load_coef(1, t, $urandom % 256);
    for (int t = 9; t < 16; t++) load_coef(1, t, $urandom % 256);
    set_ksel(1);
    set_len(5);
    stream(20, -1, 1, 1);
    drain("R3 count");

    // R2 writes lacking cs or ld
    set_ksel(0);
    set_len(7);
    cfg_wr(2, 4, 1, 1);
    cfg_wr(3, 77, 1, 0);
    cfg_wr(3, 99, 0, 1);
    cfg_wr(0, 2, 0, 1);
    cfg_wr(1, 1, 1, 0);
    stream(28, -1, 0, 0);
    drain("R2 count");

    // R5 restart mid row, then short rows R7
    set_len(8);
    stream(13, -1, 0, 0);
    set_len(2);
    stream(8, -1, 0, 0);
    drain("R7 short row count");
    set_len(3);
    stream(15, -1, 1, 0);
    drain("R5 restart count");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule